// File: doc/BRIEF.md
# Compare and Branch Resolution Unit

This unit holds the condition state of a small processor and uses it to resolve short conditional branches. A compare strobe presents two 32-bit operands. On the next clock edge the unit stores a 5-bit condition register. In that register, equality sets one flag. Signed ordering and unsigned ordering each set their own pair of flags, and both pairs are written by the same compare.

A branch strobe presents a 4-bit condition selector, a 10-bit halfword offset and the address of the branch instruction. In the same cycle the unit reports three things: whether the branch is taken, the address to fetch next, and whether the selector names no defined condition. Branches read the condition register but never write it.

Top module: `cmp_branch_unit`

## Requirements
- R1: A synchronous active-high reset clears the condition register to 5'b00000.
- R2: A compare whose operands are equal stores 5'b00100: bit 2 (equal) set and every ordering bit clear.
- R3: A compare whose operands differ sets bit 1 (signed less) or bit 0 (signed greater) from a two's-complement comparison. In the same write it sets bit 4 (unsigned less) or bit 3 (unsigned greater) from an unsigned comparison.
- R4: The condition register changes only on the clock edge that samples a compare strobe. Branch strobes and idle cycles leave it unchanged.
- R5: Selectors 0 to 9 mean, in order: equal, not equal, signed less, signed greater, unsigned less, unsigned greater, signed greater-or-equal, signed less-or-equal, unsigned greater-or-equal, unsigned less-or-equal. Not-equal tests that bit 2 is clear. Each or-equal condition tests its ordering bit OR bit 2.
- R6: Selectors 10 to 15 raise the illegal output, keep taken low and return the branch address unchanged as the next address.
- R7: The 10-bit offset is sign-extended and doubled. A taken branch yields branch address + offset*2 + 2.
- R8: A legal branch that is not taken yields branch address + 2.
- R9: Taken, illegal and next address are combinational in the cycle of the branch strobe. With no branch strobe, taken and illegal are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare strobe |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_valid | input | 1 | Branch strobe (never with cmp_valid) |
| br_cond | input | 4 | Condition selector |
| br_offset | input | 10 | Signed halfword branch offset |
| br_pc | input | 32 | Address of the branch instruction |
| cc_flags | output | 5 | Registered condition flags |
| br_taken | output | 1 | Branch is taken |
| br_next_pc | output | 32 | Next fetch address |
| br_illegal | output | 1 | Selector is undefined |

## Verification
The condition flags are due one clock edge after the compare strobe. The bench therefore drives a compare on a falling edge, lets one rising edge pass, and reads the flags on the following falling edge. Branch results are combinational, so the bench drives the branch fields on a falling edge and samples 1 ns later, before the next rising edge. A further edge is then allowed to pass so the bench can confirm that the branch left the flags unchanged.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int FL_W   = 5;
  localparam int FL_GT  = 0;
  localparam int FL_LT  = 1;
  localparam int FL_EQ  = 2;
  localparam int FL_GTU = 3;
  localparam int FL_LTU = 4;

  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_EQ  = 4'd0,
    SEL_NE  = 4'd1,
    SEL_LT  = 4'd2,
    SEL_GT  = 4'd3,
    SEL_LTU = 4'd4,
    SEL_GTU = 4'd5,
    SEL_GE  = 4'd6,
    SEL_LE  = 4'd7,
    SEL_GEU = 4'd8,
    SEL_LEU = 4'd9
  } sel_e;
endpackage

// File: rtl/cbu_compare.sv
module cbu_compare
  import cbu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   op_a,
  input  logic [DW-1:0]   op_b,
  output logic [FL_W-1:0] flags
);
  logic same, s_lt, u_lt;

  always_comb begin
    same  = (op_a == op_b);
    s_lt  = ($signed(op_a) < $signed(op_b));
    u_lt  = (op_a < op_b);
    flags = '0;
    if (same) begin
      flags[FL_EQ] = 1'b1;
    end else begin
      flags[FL_LT]  = s_lt;
      flags[FL_GT]  = !s_lt;
      flags[FL_LTU] = u_lt;
      flags[FL_GTU] = !u_lt;
    end
  end
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [FL_W-1:0]  flags,
  output logic             hit,
  output logic             bad_sel
);
  always_comb begin
    hit     = 1'b0;
    bad_sel = 1'b0;
    case (sel)
      SEL_EQ:  hit = flags[FL_EQ];
      SEL_NE:  hit = !flags[FL_EQ];
      SEL_LT:  hit = flags[FL_LT];
      SEL_GT:  hit = flags[FL_GT];
      SEL_LTU: hit = flags[FL_LTU];
      SEL_GTU: hit = flags[FL_GTU];
      SEL_GE:  hit = flags[FL_GT]  | flags[FL_EQ];
      SEL_LE:  hit = flags[FL_LT]  | flags[FL_EQ];
      SEL_GEU: hit = flags[FL_GTU] | flags[FL_EQ];
      SEL_LEU: hit = flags[FL_LTU] | flags[FL_EQ];
      default: bad_sel = 1'b1;
    endcase
  end
endmodule

// File: rtl/cbu_target.sv
module cbu_target #(
  parameter int AW    = 32,
  parameter int OFF_W = 10,
  parameter int STEP  = 2
) (
  input  logic [AW-1:0]    pc,
  input  logic [OFF_W-1:0] offset,
  input  logic             take,
  input  logic             hold,
  output logic [AW-1:0]    next_pc
);
  localparam int EXT_W = AW - OFF_W - 1;

  logic [AW-1:0] disp;
  logic [AW-1:0] seq_pc;

  always_comb begin
    disp    = {{EXT_W{offset[OFF_W-1]}}, offset, 1'b0};
    seq_pc  = pc + AW'(STEP);
    if (hold)      next_pc = pc;
    else if (take) next_pc = seq_pc + disp;
    else           next_pc = seq_pc;
  end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_valid,
  input  logic [DW-1:0]    cmp_a,
  input  logic [DW-1:0]    cmp_b,
  input  logic             br_valid,
  input  logic [3:0]       br_cond,
  input  logic [OFF_W-1:0] br_offset,
  input  logic [DW-1:0]    br_pc,
  output logic [4:0]       cc_flags,
  output logic             br_taken,
  output logic [DW-1:0]    br_next_pc,
  output logic             br_illegal
);
  logic [FL_W-1:0] cmp_flags;
  logic [FL_W-1:0] flags_q;
  logic            cond_hit, cond_bad;

  cbu_compare #(.DW(DW)) u_cmp (
    .op_a  (cmp_a),
    .op_b  (cmp_b),
    .flags (cmp_flags)
  );

  always_ff @(posedge clk) begin
    if (rst)            flags_q <= '0;
    else if (cmp_valid) flags_q <= cmp_flags;
  end

  assign cc_flags = flags_q;

  cbu_cond_eval u_eval (
    .sel     (br_cond),
    .flags   (flags_q),
    .hit     (cond_hit),
    .bad_sel (cond_bad)
  );

  assign br_taken   = br_valid & cond_hit;
  assign br_illegal = br_valid & cond_bad;

  cbu_target #(.AW(DW), .OFF_W(OFF_W), .STEP(2)) u_tgt (
    .pc      (br_pc),
    .offset  (br_offset),
    .take    (br_taken),
    .hold    (br_illegal),
    .next_pc (br_next_pc)
  );

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> cc_flags == 5'b00000);

  a_r2_equal_only: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_a == cmp_b) |=> cc_flags == 5'b00100);

  a_r3_signed_less: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && $signed(cmp_a) < $signed(cmp_b)) |=> (cc_flags[1] && !cc_flags[0]));

  a_r3_unsigned_pair: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_a != cmp_b) |=> $countones({cc_flags[4], cc_flags[3]}) == 1);

  a_r4_hold_flags: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> $stable(cc_flags));

  a_r6_illegal_hold: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_cond > 4'd9) |-> (br_illegal && !br_taken && br_next_pc == br_pc));

  a_r8_fallthrough: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !br_taken && !br_illegal) |-> br_next_pc == br_pc + 32'd2);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !br_valid |-> (!br_taken && !br_illegal));
endmodule

// File: tb/cmp_branch_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_a = '0, cmp_b = '0;
  logic        br_valid = 1'b0;
  logic [3:0]  br_cond = '0;
  logic [9:0]  br_offset = '0;
  logic [31:0] br_pc = '0;
  logic [4:0]  cc_flags;
  logic        br_taken, br_illegal;
  logic [31:0] br_next_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_branch_unit dut_i (
    .clk(clk), .rst(rst),
    .cmp_valid(cmp_valid), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .br_valid(br_valid), .br_cond(br_cond), .br_offset(br_offset), .br_pc(br_pc),
    .cc_flags(cc_flags), .br_taken(br_taken), .br_next_pc(br_next_pc),
    .br_illegal(br_illegal)
  );

  // {a, b, expected flags}; flags: 0 GT, 1 LT, 2 EQ, 3 GTU, 4 LTU
  localparam logic [68:0] VEC [8] = '{
    {32'd5,        32'd5,        5'h04},
    {32'd1,        32'd2,        5'h12},
    {32'd2,        32'd1,        5'h09},
    {32'hFFFFFFFF, 32'd1,        5'h0A},
    {32'd1,        32'hFFFFFFFF, 5'h11},
    {32'h80000000, 32'h7FFFFFFF, 5'h0A},
    {32'd0,        32'd0,        5'h04},
    {32'hFFFFFFFF, 32'hFFFFFFFE, 5'h09}
  };

  localparam logic [9:0] OFFS [3] = '{10'h3FF, 10'h1FF, 10'h200};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit cond_model(input logic [3:0] c, input logic [4:0] f);
    case (c)
      4'd0: return f[2];
      4'd1: return !f[2];
      4'd2: return f[1];
      4'd3: return f[0];
      4'd4: return f[4];
      4'd5: return f[3];
      4'd6: return f[0] | f[2];
      4'd7: return f[1] | f[2];
      4'd8: return f[3] | f[2];
      4'd9: return f[4] | f[2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic do_cmp(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_a = a; cmp_b = b;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic do_branch(input logic [3:0] c, input logic [9:0] off,
                           input logic [31:0] pc, input logic [4:0] f);
    int so;
    logic [31:0] exp_pc;
    bit t;
    so = off[9] ? int'(off) - 1024 : int'(off);
    t = cond_model(c, f);
    if (c > 4'd9)  exp_pc = pc;
    else if (t)    exp_pc = pc + 32'd2 + 32'(2 * so);
    else           exp_pc = pc + 32'd2;
    br_valid = 1'b1; br_cond = c; br_offset = off; br_pc = pc;
    #1;
    if (c > 4'd9) begin
      chk("R6 illegal", {31'd0, br_illegal}, 32'd1);
      chk("R6 not taken", {31'd0, br_taken}, 32'd0);
      chk("R6 pc held", br_next_pc, exp_pc);
    end else begin
      chk("R5 taken", {31'd0, br_taken}, {31'd0, t});
      chk("R9 no illegal", {31'd0, br_illegal}, 32'd0);
      chk(t ? "R7 target" : "R8 fallthrough", br_next_pc, exp_pc);
    end
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset flags", {27'd0, cc_flags}, 32'd0);
    #1;
    chk("R9 idle taken", {31'd0, br_taken}, 32'd0);
    chk("R9 idle illegal", {31'd0, br_illegal}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      logic [4:0] ef;
      ef = VEC[i][4:0];
      do_cmp(VEC[i][68:37], VEC[i][36:5]);
      chk(ef == 5'h04 ? "R2 equal flags" : "R3 order flags", {27'd0, cc_flags}, {27'd0, ef});
      for (int c = 0; c < 16; c++) begin
        do_branch(4'(c), OFFS[c % 3], 32'h0000_1000 + 32'(i * 64), ef);
      end
      chk("R4 flags kept after branches", {27'd0, cc_flags}, {27'd0, ef});
    end

    // R7 extreme offsets with an always-taken condition (equal after equal compare)
    do_cmp(32'd7, 32'd7);
    do_branch(4'd0, 10'h200, 32'h0000_0800, 5'h04);
    do_branch(4'd0, 10'h1FF, 32'h0000_0800, 5'h04);
    do_branch(4'd0, 10'h000, 32'h0000_0800, 5'h04);

    // R4: idle cycles keep flags
    repeat (4) @(negedge clk);
    chk("R4 idle hold", {27'd0, cc_flags}, 32'h04);

    // R1: reset mid-run clears flags
    do_cmp(32'd1, 32'd9);
    chk("R3 before reset", {27'd0, cc_flags}, 32'h12);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-run reset", {27'd0, cc_flags}, 32'd0);

    done = 1'b1;
    summary();
  end
endmodule